// File: doc/BRIEF.md
# Three-Channel Wiper Register Command Engine

This block keeps the wiper settings of three digitally adjusted resistor channels. Channels 0 and 1 have 9-bit wipers (512 positions) and channel 2 has a 7-bit wiper (128 positions). Each channel has a working register and a shadow word that stands in for nonvolatile storage. A host issues 4-bit shortcut commands with a strobe and a channel select. The commands cover linear one-step moves, ±6 dB moves made by shifting, copies between a register and its shadow, and a restore of every channel. A command acts on the selected channel or on all three channels. Copies to and from the shadow take several clocks, and during that time the `busy` output is high.

Control is a three-state machine. In `ST_IDLE` the engine decodes the command on the cycle it is presented. A step command updates the registers on that same edge and the machine stays in `ST_IDLE`. An accepted store moves the machine `ST_IDLE → ST_STORE`, and the shadow word is written when the store counter expires (`ST_STORE → ST_IDLE`). A restore command, or the restore pin seen while idle, moves the machine `ST_IDLE → ST_RESTORE`, and the registers are loaded when the restore counter expires (`ST_RESTORE → ST_IDLE`). The active-low write-protect input blocks every change except restores.

Top module: `wiper_cmd_engine`

## Requirements
- R1: After `rst_n` is released, both shadows and registers hold midscale: 256 on `wiper0` and `wiper1`, 64 on `wiper2`. `busy` is 0.
- R2: Code 10 adds one to the channel selected by `cmd_chan`, and code 11 adds one to every channel. A value already at full scale (511 on a 9-bit channel, 127 on the 7-bit channel) stays there.
- R3: Code 5 subtracts one from the selected channel, and code 6 subtracts one from every channel. A value of 0 stays at 0.
- R4: Code 8 doubles the selected channel and code 9 doubles every channel, by shifting left. A value of 0 becomes 1. A value at or above midscale (256 or 64) becomes full scale.
- R5: Code 3 halves the selected channel and code 4 halves every channel, by shifting right and dropping the LSB. A value of 0 stays 0.
- R6: Code 2 copies the selected register into its shadow. `busy` goes high from the cycle after acceptance for exactly STORE_CYCLES cycles, and the shadow is written when `busy` falls.
- R7: Code 1 loads the selected register from its shadow. `busy` is high for exactly RESTORE_CYCLES cycles, and the register changes on the edge where `busy` falls. The other channels do not change.
- R8: Code 7, or `restore_pin` high while idle, loads all three registers from their shadows with the same busy timing as R7. This also happens when `wp_n` is low.
- R9: While `wp_n` is 0, codes 2 to 6 and 8 to 11 change neither registers nor shadows, and `busy` is not raised.
- R10: A command presented while `busy` is high is dropped.
- R11: Codes 0 and 12 to 15 have no effect. A single-channel command (codes 1, 2, 3, 5, 8, 10) with `cmd_chan` of 3 to 7 has no effect. All-channel commands ignore `cmd_chan`.
- R12: Step commands (codes 3 to 6 and 8 to 11) change the registers on the clock edge that accepts them, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| restore_pin | input | 1 | Level request to restore all channels from the shadows |
| wp_n | input | 1 | Write protect, active low |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 4 | Shortcut command code |
| cmd_chan | input | 3 | Channel select, 0 to 2 valid |
| wiper0 | output | W_HI | Channel 0 wiper register |
| wiper1 | output | W_HI | Channel 1 wiper register |
| wiper2 | output | W_LO | Channel 2 wiper register |
| busy | output | 1 | High during a store or restore |

## Verification
The assertions assume the following about the inputs:
- `cmd_code`, `cmd_chan` and `wp_n` are steady around each sampling edge.
- `restore_pin` is a level that is honoured only in `ST_IDLE`.
- A command is one `cmd_valid` cycle.

The stimulus changes every input on the falling clock edge. Each command is a single-cycle strobe. The next command waits until `busy` has cleared, except in the dedicated drop test, which presents a command in the middle of a store on purpose. Restore-pin pulses last one cycle and are given only while idle. Random command codes, out-of-range selects and write-protect settings are mixed in, and each result is compared against a model of the shift and saturation rules.

// File: rtl/wiper_pkg.sv
`timescale 1ns/1ps
package wiper_pkg;

    typedef enum logic [3:0] {
        CMD_NOP         = 4'd0,
        CMD_RESTORE_ONE = 4'd1,
        CMD_STORE_ONE   = 4'd2,
        CMD_HALF_ONE    = 4'd3,
        CMD_HALF_ALL    = 4'd4,
        CMD_DEC_ONE     = 4'd5,
        CMD_DEC_ALL     = 4'd6,
        CMD_RESTORE_ALL = 4'd7,
        CMD_DBL_ONE     = 4'd8,
        CMD_DBL_ALL     = 4'd9,
        CMD_INC_ONE     = 4'd10,
        CMD_INC_ALL     = 4'd11
    } cmd_e;

    typedef enum logic [1:0] {OP_INC, OP_DEC, OP_DBL, OP_HALF} op_e;

    typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_RESTORE} state_e;

    typedef enum logic [1:0] {ACC_NONE, ACC_STEP, ACC_STORE, ACC_RESTORE} acc_e;

endpackage

// File: rtl/wiper_step.sv
`timescale 1ns/1ps
module wiper_step
    import wiper_pkg::*;
#(
    parameter int W = 9
) (
    input  logic [W-1:0] cur,
    input  op_e          op,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] FULL = {W{1'b1}};
    localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        unique case (op)
            OP_INC:  nxt = (cur == FULL) ? FULL : cur + 1'b1;
            OP_DEC:  nxt = (cur == '0) ? '0 : cur - 1'b1;
            OP_DBL: begin
                if (cur == '0)       nxt = W'(1);
                else if (cur >= MID) nxt = FULL;
                else                 nxt = cur << 1;
            end
            OP_HALF: nxt = cur >> 1;
        endcase
    end
endmodule

// File: rtl/wiper_channel.sv
`timescale 1ns/1ps
module wiper_channel
    import wiper_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         load_en,
    input  logic         store_en,
    input  op_e          op,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] shadow_q;
    logic [W-1:0] step_q;

    wiper_step #(.W(W)) u_step (
        .cur (q),
        .op  (op),
        .nxt (step_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= MID;
            shadow_q <= MID;
        end else begin
            if (store_en) shadow_q <= q;
            if (load_en)      q <= shadow_q;
            else if (step_en) q <= step_q;
        end
    end
endmodule

// File: rtl/wiper_cmd_engine.sv
`timescale 1ns/1ps
module wiper_cmd_engine
    import wiper_pkg::*;
#(
    parameter int W_HI           = 9,
    parameter int W_LO           = 7,
    parameter int STORE_CYCLES   = 16,
    parameter int RESTORE_CYCLES = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restore_pin,
    input  logic            wp_n,
    input  logic            cmd_valid,
    input  logic [3:0]      cmd_code,
    input  logic [2:0]      cmd_chan,
    output logic [W_HI-1:0] wiper0,
    output logic [W_HI-1:0] wiper1,
    output logic [W_LO-1:0] wiper2,
    output logic            busy
);
    localparam int NCH   = 3;
    localparam int MAXC  = (STORE_CYCLES > RESTORE_CYCLES) ? STORE_CYCLES : RESTORE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] STORE_LAST   = CNT_W'(STORE_CYCLES - 1);
    localparam logic [CNT_W-1:0] RESTORE_LAST = CNT_W'(RESTORE_CYCLES - 1);
    localparam logic [NCH-1:0]   ALL_CH       = '1;

    state_e             state_q, state_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic [NCH-1:0]     mask_q, mask_n;

    acc_e               acc;
    logic [NCH-1:0]     acc_mask;
    op_e                acc_op;
    logic               is_step, is_all;
    logic               chan_ok;
    logic [NCH-1:0]     sel_mask;

    logic [NCH-1:0]     step_en, load_en, store_en;

    assign chan_ok  = cmd_chan < 3'(NCH);
    assign sel_mask = chan_ok ? (NCH'(1) << cmd_chan) : '0;

    // command decode: what an idle engine would accept this cycle
    always_comb begin
        acc      = ACC_NONE;
        acc_mask = '0;
        acc_op   = OP_INC;
        is_step  = 1'b0;
        is_all   = 1'b0;
        if (restore_pin) begin
            acc      = ACC_RESTORE;
            acc_mask = ALL_CH;
        end else if (cmd_valid) begin
            case (cmd_code)
                CMD_RESTORE_ONE: if (chan_ok) begin
                    acc      = ACC_RESTORE;
                    acc_mask = sel_mask;
                end
                CMD_RESTORE_ALL: begin
                    acc      = ACC_RESTORE;
                    acc_mask = ALL_CH;
                end
                CMD_STORE_ONE: if (chan_ok && wp_n) begin
                    acc      = ACC_STORE;
                    acc_mask = sel_mask;
                end
                CMD_HALF_ONE: begin is_step = 1'b1; acc_op = OP_HALF; end
                CMD_HALF_ALL: begin is_step = 1'b1; is_all = 1'b1; acc_op = OP_HALF; end
                CMD_DEC_ONE:  begin is_step = 1'b1; acc_op = OP_DEC; end
                CMD_DEC_ALL:  begin is_step = 1'b1; is_all = 1'b1; acc_op = OP_DEC; end
                CMD_DBL_ONE:  begin is_step = 1'b1; acc_op = OP_DBL; end
                CMD_DBL_ALL:  begin is_step = 1'b1; is_all = 1'b1; acc_op = OP_DBL; end
                CMD_INC_ONE:  begin is_step = 1'b1; acc_op = OP_INC; end
                CMD_INC_ALL:  begin is_step = 1'b1; is_all = 1'b1; acc_op = OP_INC; end
                default: ;
            endcase
            if (is_step && wp_n && (is_all || chan_ok)) begin
                acc      = ACC_STEP;
                acc_mask = is_all ? ALL_CH : sel_mask;
            end
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        mask_n  = mask_q;
        unique case (state_q)
            ST_IDLE: begin
                case (acc)
                    ACC_STORE: begin
                        state_n = ST_STORE;
                        cnt_n   = STORE_LAST;
                        mask_n  = acc_mask;
                    end
                    ACC_RESTORE: begin
                        state_n = ST_RESTORE;
                        cnt_n   = RESTORE_LAST;
                        mask_n  = acc_mask;
                    end
                    default: ;
                endcase
            end
            ST_STORE, ST_RESTORE: begin
                if (cnt_q == '0) begin
                    state_n = ST_IDLE;
                    mask_n  = '0;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            mask_q  <= mask_n;
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        step_en  = (state_q == ST_IDLE && acc == ACC_STEP) ? acc_mask : '0;
        store_en = (state_q == ST_STORE && cnt_q == '0) ? mask_q : '0;
        load_en  = (state_q == ST_RESTORE && cnt_q == '0) ? mask_q : '0;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int CW = (g == NCH - 1) ? W_LO : W_HI;
        logic [CW-1:0] ch_q;

        wiper_channel #(.W(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_en  (step_en[g]),
            .load_en  (load_en[g]),
            .store_en (store_en[g]),
            .op       (acc_op),
            .q        (ch_q)
        );

        if (g == 0) begin : g_o0
            assign wiper0 = ch_q;
        end else if (g == 1) begin : g_o1
            assign wiper1 = ch_q;
        end else begin : g_o2
            assign wiper2 = ch_q;
        end
    end
endmodule

// File: rtl/wiper_cmd_engine_chk.sv
`timescale 1ns/1ps
module wiper_cmd_engine_chk #(
    parameter int W_HI = 9,
    parameter int W_LO = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            restore_pin,
    input logic            wp_n,
    input logic            cmd_valid,
    input logic [3:0]      cmd_code,
    input logic [2:0]      cmd_chan,
    input logic [W_HI-1:0] wiper0,
    input logic [W_HI-1:0] wiper1,
    input logic [W_LO-1:0] wiper2,
    input logic            busy
);
    logic idle_cmd;
    assign idle_cmd = !busy && cmd_valid && !restore_pin;

    a_r2_inc_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && wp_n && cmd_code == 4'd10 && cmd_chan == 3'd0 && wiper0 == '1)
        |=> (wiper0 == '1));

    a_r4_double_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && wp_n && cmd_code == 4'd8 && cmd_chan == 3'd2 && wiper2 == '0)
        |=> (wiper2 == W_LO'(1)));

    a_r5_halve_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && wp_n && cmd_code == 4'd4 && wiper1 == '0)
        |=> (wiper1 == '0));

    a_r6_store_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && wp_n && cmd_code == 4'd2 && cmd_chan < 3'd3)
        |=> busy);

    a_r9_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && !busy)
        |=> ($stable(wiper0) && $stable(wiper1) && $stable(wiper2)));

    a_r10_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        busy
        |=> (!busy || ($stable(wiper0) && $stable(wiper1) && $stable(wiper2))));

    a_r11_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && cmd_code >= 4'd12)
        |=> (!busy && $stable(wiper0) && $stable(wiper1) && $stable(wiper2)));

    a_r12_step_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && cmd_code == 4'd10)
        |=> !busy);
endmodule

bind wiper_cmd_engine wiper_cmd_engine_chk #(.W_HI(W_HI), .W_LO(W_LO)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restore_pin (restore_pin),
    .wp_n        (wp_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_chan    (cmd_chan),
    .wiper0      (wiper0),
    .wiper1      (wiper1),
    .wiper2      (wiper2),
    .busy        (busy)
);

// File: tb/wiper_cmd_engine_bench.sv
`timescale 1ns/1ps
module wiper_cmd_engine_bench;
    localparam int SC = 16;
    localparam int RC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restore_pin = 1'b0;
    logic       wp_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = '0;
    logic [2:0] cmd_chan = '0;
    logic [8:0] wiper0, wiper1;
    logic [6:0] wiper2;
    logic       busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int m_w [3];
    int m_s [3];

    always #2.5 clk = ~clk;

    wiper_cmd_engine #(
        .W_HI(9), .W_LO(7), .STORE_CYCLES(SC), .RESTORE_CYCLES(RC)
    ) u_wiper_cmd_engine (
        .clk(clk), .rst_n(rst_n), .restore_pin(restore_pin), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_chan(cmd_chan),
        .wiper0(wiper0), .wiper1(wiper1), .wiper2(wiper2), .busy(busy)
    );

    function automatic int wid(input int ch);
        return (ch == 2) ? 7 : 9;
    endfunction

    // op: 0 inc, 1 dec, 2 double, 3 halve
    function automatic int m_step(input int x, input int op, input int w);
        int full = (1 << w) - 1;
        int mid  = 1 << (w - 1);
        case (op)
            0: return (x == full) ? full : x + 1;
            1: return (x == 0) ? 0 : x - 1;
            2: return (x == 0) ? 1 : ((x >= mid) ? full : 2 * x);
            default: return x / 2;
        endcase
    endfunction

    function automatic string tag_of(input int code, input int chan, input bit wp);
        if (code == 0 || code >= 12) return "R11";
        if (chan >= 3 && (code == 1 || code == 2 || code == 3 || code == 5 || code == 8 || code == 10))
            return "R11";
        if (code == 1) return "R7";
        if (code == 7) return "R8";
        if (!wp) return "R9";
        case (code)
            2: return "R6";
            3, 4: return "R5";
            5, 6: return "R3";
            8, 9: return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "wiper0", int'(wiper0), m_w[0]);
        check(tag, "wiper1", int'(wiper1), m_w[1]);
        check(tag, "wiper2", int'(wiper2), m_w[2]);
    endtask

    task automatic wait_idle(output int nb);
        nb = 0;
        while (busy && nb < 1000) begin
            nb++;
            @(negedge clk);
        end
    endtask

    // starts and ends at a falling edge
    task automatic issue(input int code, input int chan, input bit wp, input string tag);
        int exp_b = 0;
        int nb;
        int op = -1;
        bit all = 1'b0;
        bit ok_ch = (chan < 3);
        case (code)
            1: if (ok_ch) begin m_w[chan] = m_s[chan]; exp_b = RC; end
            7: begin for (int i = 0; i < 3; i++) m_w[i] = m_s[i]; exp_b = RC; end
            2: if (ok_ch && wp) begin m_s[chan] = m_w[chan]; exp_b = SC; end
            3: op = 3;
            4: begin op = 3; all = 1'b1; end
            5: op = 1;
            6: begin op = 1; all = 1'b1; end
            8: op = 2;
            9: begin op = 2; all = 1'b1; end
            10: op = 0;
            11: begin op = 0; all = 1'b1; end
            default: ;
        endcase
        if (op >= 0 && wp)
            for (int i = 0; i < 3; i++)
                if (all || i == chan) m_w[i] = m_step(m_w[i], op, wid(i));
        cmd_valid = 1'b1;
        cmd_code  = 4'(code);
        cmd_chan  = 3'(chan);
        wp_n      = wp;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle(nb);
        wp_n = 1'b1;
        check(tag, "busy cycles", nb, exp_b);
        check_all(tag);
    endtask

    task automatic pulse_pin(input bit wp);
        int nb;
        restore_pin = 1'b1;
        wp_n = wp;
        @(negedge clk);
        restore_pin = 1'b0;
        for (int i = 0; i < 3; i++) m_w[i] = m_s[i];
        wait_idle(nb);
        wp_n = 1'b1;
        check("R8", "pin busy cycles", nb, RC);
        check_all("R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nb;
        void'($urandom(32'd4242));
        for (int i = 0; i < 2; i++) m_w[i] = 256;
        m_w[2] = 64;
        for (int i = 0; i < 3; i++) m_s[i] = m_w[i];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "wiper0 reset", int'(wiper0), 256);
        check("R1", "wiper1 reset", int'(wiper1), 256);
        check("R1", "wiper2 reset", int'(wiper2), 64);
        check("R1", "busy reset", int'(busy), 0);

        issue(10, 0, 1'b1, "R12");
        check("R2", "inc ch0", int'(wiper0), 257);
        for (int k = 0; k < 9; k++) issue(3, 0, 1'b1, "R5");
        check("R5", "halve to zero", int'(wiper0), 0);
        issue(3, 0, 1'b1, "R5");
        check("R5", "halve zero", int'(wiper0), 0);
        issue(8, 0, 1'b1, "R4");
        check("R4", "double zero", int'(wiper0), 1);
        issue(5, 0, 1'b1, "R3");
        issue(5, 0, 1'b1, "R3");
        check("R3", "dec floor", int'(wiper0), 0);
        issue(8, 2, 1'b1, "R4");
        check("R4", "double mid 7b", int'(wiper2), 127);
        issue(10, 2, 1'b1, "R2");
        check("R2", "inc ceiling 7b", int'(wiper2), 127);
        issue(9, 6, 1'b1, "R4");
        check("R4", "double all ch1", int'(wiper1), 511);
        issue(11, 0, 1'b1, "R2");
        check("R2", "inc ceiling 9b", int'(wiper1), 511);
        issue(2, 1, 1'b1, "R6");
        issue(5, 1, 1'b1, "R3");
        issue(1, 1, 1'b1, "R7");
        check("R7", "restore ch1", int'(wiper1), 511);
        issue(10, 0, 1'b0, "R9");
        issue(2, 0, 1'b0, "R9");
        issue(7, 0, 1'b0, "R8");
        issue(10, 0, 1'b1, "R2");
        pulse_pin(1'b0);

        // R10: a command arriving mid-store is dropped
        cmd_valid = 1'b1; cmd_code = 4'd2; cmd_chan = 3'd0;
        m_s[0] = m_w[0];
        @(negedge clk);
        cmd_code = 4'd10;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle(nb);
        check("R10", "store busy cycles", nb + 1, SC);
        check_all("R10");

        for (int c = 12; c < 16; c++) issue(c, 0, 1'b1, "R11");
        issue(0, 1, 1'b1, "R11");
        issue(10, 5, 1'b1, "R11");
        issue(2, 7, 1'b1, "R11");
        issue(6, 7, 1'b1, "R11");

        for (int n = 0; n < 400; n++) begin
            int code = $urandom_range(15, 0);
            int chan = ($urandom_range(7, 0) < 6) ? $urandom_range(2, 0) : $urandom_range(7, 3);
            bit wp = ($urandom_range(9, 0) != 0);
            if ($urandom_range(19, 0) == 0) pulse_pin(wp);
            else issue(code, chan, wp, tag_of(code, chan, wp));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule